// File: doc/BRIEF.md
# Cartridge Bank Mapper with Nine-Bit ROM Select

This block turns CPU writes into the control state of a cartridge mapper. The CPU writes into the ROM address space, and the mapper catches each write by its upper address nibble. It keeps four pieces of state: a 9-bit bank number for the switchable ROM window, a 4-bit bank number for cartridge RAM, a flag that enables cartridge RAM, and, in one build variant, a drive level for a vibration motor. The switchable ROM bank is assembled from two separate writes, a full low byte and a single high bit. Bank 0 is a legal selection in the switchable window. The fixed ROM window is not handled here and always maps to bank 0.

The write port is a plain strobe with address and data, and it has no back-pressure. When `wr_en` is high at a rising clock edge, the write is accepted and decoded in that cycle. A write that lands in a region with no function is dropped without any effect. All outputs come from registers and show a write's effect one clock after the write. The parameter `RUMBLE_EN` selects the variant. With it set, bit 3 of a RAM-bank write drives the motor output, and that bit is forced to zero in the stored RAM bank.

Top module: `cart_bank_mapper`

## Requirements
- R1: While reset is asserted and right after it is released, `rom_bank` is 1, `ram_bank` is 0, `ram_en` is 0 and `rumble` is 0.
- R2: A write whose `wr_addr[15:12]` is 0x0 or 0x1 sets `ram_en` to 1 when the data is 0x0A and clears it when the data is 0x00.
- R3: A write to region 0x0 or 0x1 with any data other than 0x00 or 0x0A leaves `ram_en` unchanged.
- R4: A write to region 0x2 replaces `rom_bank[7:0]` with the full data byte and keeps `rom_bank[8]`.
- R5: A write to region 0x3 loads `rom_bank[8]` from data bit 0, ignores data bits [7:1] and keeps `rom_bank[7:0]`.
- R6: A `rom_bank` value of 0 is stored and shown as 0. It is never replaced by 1.
- R7: A write to region 0x4 or 0x5 loads `ram_bank` from data bits [3:0]. With `RUMBLE_EN`=0 all four bits are kept.
- R8: With `RUMBLE_EN`=1, a write to region 0x4 or 0x5 sets `rumble` to data bit 3 and stores `ram_bank` with bit 3 cleared.
- R9: A write to any region from 0x6 to 0xF changes no output.
- R10: While `wr_en` is low, no output changes, whatever the address and data are.
- R11: With `RUMBLE_EN`=0, `rumble` stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. State changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe. A write is accepted when this is high at a rising edge |
| wr_addr | input | 16 | CPU write address. Bits [15:12] select the region |
| wr_data | input | 8 | CPU write data |
| rom_bank | output | 9 | Bank number for the switchable ROM window |
| ram_bank | output | 4 | Bank number for cartridge RAM |
| ram_en | output | 1 | Cartridge RAM enable |
| rumble | output | 1 | Motor drive level. Held at 0 when `RUMBLE_EN`=0 |

## Verification
The bench builds two copies of the mapper side by side on the same write stream. One copy has `RUMBLE_EN`=1 and the other has `RUMBLE_EN`=0, and both use the default widths. The rumble copy lets the bench check that bit 3 is taken out of the RAM-bank write and drives the motor output. The plain copy shows that, without the variant, the same write keeps all four bank bits and the motor output never rises. Together the two copies cover both branches of the generate block in the RAM control logic.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  // Region codes taken from the upper address nibble; their values are the decode.
  typedef enum logic [3:0] {
    RG_RAMEN_A  = 4'h0,
    RG_RAMEN_B  = 4'h1,
    RG_ROM_LO   = 4'h2,
    RG_ROM_HI   = 4'h3,
    RG_RAMBNK_A = 4'h4,
    RG_RAMBNK_B = 4'h5
  } region_e;

  typedef struct packed {
    logic ram_en_sel;
    logic rom_lo_sel;
    logic rom_hi_sel;
    logic ram_bank_sel;
  } wr_sel_t;

  localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
  localparam logic [7:0] RAM_OFF_CODE = 8'h00;
endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_map_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output wr_sel_t           sel
);
  localparam int RG_LSB = ADDR_W - 4;

  logic [3:0] region;
  assign region = wr_addr[ADDR_W-1:RG_LSB];

  always_comb begin
    sel = '0;
    if (wr_en) begin
      unique case (region)
        RG_RAMEN_A,  RG_RAMEN_B:  sel.ram_en_sel   = 1'b1;
        RG_ROM_LO:                sel.rom_lo_sel   = 1'b1;
        RG_ROM_HI:                sel.rom_hi_sel   = 1'b1;
        RG_RAMBNK_A, RG_RAMBNK_B: sel.ram_bank_sel = 1'b1;
        default:                  sel = '0;
      endcase
    end
  end

  always_comb begin
    AST_ONE_TARGET: assert ($onehot0(sel)); // R9
  end
endmodule

// File: rtl/cart_rom_bank_reg.sv
module cart_rom_bank_reg #(
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lo_sel,
  input  logic                  hi_sel,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [ROM_BANK_W-1:0] bank
);
  localparam int HI_W = ROM_BANK_W - DATA_W;
  localparam logic [ROM_BANK_W-1:0] RESET_BANK = ROM_BANK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= RESET_BANK;
    end else if (lo_sel) begin
      bank[DATA_W-1:0] <= wr_data;
    end else if (hi_sel) begin
      bank[ROM_BANK_W-1:DATA_W] <= wr_data[HI_W-1:0];
    end
  end

  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    lo_sel |=> bank[ROM_BANK_W-1:DATA_W] == $past(bank[ROM_BANK_W-1:DATA_W])); // R4
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hi_sel |=> bank[DATA_W-1:0] == $past(bank[DATA_W-1:0])); // R5
  AST_ZERO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_sel && wr_data == '0 && bank[ROM_BANK_W-1:DATA_W] == '0) |=> bank == '0); // R6
endmodule

// File: rtl/cart_ram_ctrl.sv
module cart_ram_ctrl
  import cart_map_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RAM_BANK_W = 4,
  parameter bit RUMBLE_EN  = 1'b1,
  parameter int RUMBLE_BIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_sel,
  input  logic                  bank_sel,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [RAM_BANK_W-1:0] bank,
  output logic                  ram_en,
  output logic                  rumble
);
  logic [RAM_BANK_W-1:0] bank_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_en <= 1'b0;
    end else if (en_sel) begin
      if (wr_data == RAM_ON_CODE)       ram_en <= 1'b1;
      else if (wr_data == RAM_OFF_CODE) ram_en <= 1'b0;
    end
  end

  generate
    if (RUMBLE_EN) begin : g_rumble
      always_comb begin
        bank_in = wr_data[RAM_BANK_W-1:0];
        bank_in[RUMBLE_BIT] = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rumble <= 1'b0;
        else if (bank_sel) rumble <= wr_data[RUMBLE_BIT];
      end
      AST_MOTOR_BIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel |=> !bank[RUMBLE_BIT]); // R8
    end else begin : g_plain
      assign bank_in = wr_data[RAM_BANK_W-1:0];
      assign rumble  = 1'b0;
      always_comb begin
        AST_NO_MOTOR: assert (rumble == 1'b0); // R11
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bank <= '0;
    else if (bank_sel) bank <= bank_in;
  end

  AST_RAM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sel && wr_data == RAM_ON_CODE) |=> ram_en); // R2
  AST_RAM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sel && wr_data == RAM_OFF_CODE) |=> !ram_en); // R2
  AST_RAM_JUNK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sel && wr_data != RAM_ON_CODE && wr_data != RAM_OFF_CODE) |=> $stable(ram_en)); // R3
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 9,
  parameter int RAM_BANK_W = 4,
  parameter bit RUMBLE_EN  = 1'b1,
  parameter int RUMBLE_BIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en,
  output logic                  rumble
);
  localparam int RG_LSB = ADDR_W - 4;

  wr_sel_t sel;

  cart_wr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .sel     (sel)
  );

  cart_rom_bank_reg #(.DATA_W(DATA_W), .ROM_BANK_W(ROM_BANK_W)) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_sel  (sel.rom_lo_sel),
    .hi_sel  (sel.rom_hi_sel),
    .wr_data (wr_data),
    .bank    (rom_bank)
  );

  cart_ram_ctrl #(
    .DATA_W(DATA_W), .RAM_BANK_W(RAM_BANK_W),
    .RUMBLE_EN(RUMBLE_EN), .RUMBLE_BIT(RUMBLE_BIT)
  ) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_sel   (sel.ram_en_sel),
    .bank_sel (sel.ram_bank_sel),
    .wr_data  (wr_data),
    .bank     (ram_bank),
    .ram_en   (ram_en),
    .rumble   (rumble)
  );

  AST_DEAD_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[ADDR_W-1:RG_LSB] >= 4'h6) |=>
      ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(rumble))); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en) && $stable(rumble))); // R10
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [8:0]  rom_bank, p_rom;
  logic [3:0]  ram_bank, p_ram;
  logic        ram_en, rumble, p_en, p_rum;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  cart_bank_mapper #(.RUMBLE_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en), .rumble(rumble));

  cart_bank_mapper #(.RUMBLE_EN(1'b0)) dut_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_bank(p_rom), .ram_bank(p_ram), .ram_en(p_en), .rumble(p_rum));

  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [8:0]  rom;
    logic [3:0]  ram;
    logic        en;
    logic        rum;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b1, 16'h0000, 8'h0A, 9'h001, 4'h0, 1'b1, 1'b0}, // R2 enable
    '{8'd3,  1'b1, 16'h1FFF, 8'h05, 9'h001, 4'h0, 1'b1, 1'b0}, // R3 junk ignored
    '{8'd2,  1'b1, 16'h1000, 8'h00, 9'h001, 4'h0, 1'b0, 1'b0}, // R2 disable
    '{8'd3,  1'b1, 16'h0123, 8'h0B, 9'h001, 4'h0, 1'b0, 1'b0}, // R3 junk ignored
    '{8'd2,  1'b1, 16'h1000, 8'h0A, 9'h001, 4'h0, 1'b1, 1'b0}, // R2 enable via 0x1
    '{8'd4,  1'b1, 16'h2000, 8'hA5, 9'h0A5, 4'h0, 1'b1, 1'b0}, // R4 low byte
    '{8'd5,  1'b1, 16'h3000, 8'hFF, 9'h1A5, 4'h0, 1'b1, 1'b0}, // R5 high bit, upper data ignored
    '{8'd4,  1'b1, 16'h2FFF, 8'h00, 9'h100, 4'h0, 1'b1, 1'b0}, // R4 keeps bit 8
    '{8'd6,  1'b1, 16'h3ABC, 8'hFE, 9'h000, 4'h0, 1'b1, 1'b0}, // R6 bank zero kept
    '{8'd8,  1'b1, 16'h4000, 8'h0F, 9'h000, 4'h7, 1'b1, 1'b1}, // R8 motor on, bit 3 stripped
    '{8'd7,  1'b1, 16'h5000, 8'h04, 9'h000, 4'h4, 1'b1, 1'b0}, // R7 plain bank
    '{8'd8,  1'b1, 16'h5FFF, 8'hF9, 9'h000, 4'h1, 1'b1, 1'b1}, // R8 motor on again
    '{8'd9,  1'b1, 16'h6000, 8'h00, 9'h000, 4'h1, 1'b1, 1'b1}, // R9 region 6
    '{8'd9,  1'b1, 16'h7FFF, 8'h0A, 9'h000, 4'h1, 1'b1, 1'b1}, // R9 region 7
    '{8'd9,  1'b1, 16'hA000, 8'h00, 9'h000, 4'h1, 1'b1, 1'b1}, // R9 region A
    '{8'd10, 1'b0, 16'h2000, 8'h33, 9'h000, 4'h1, 1'b1, 1'b1}, // R10 no strobe
    '{8'd10, 1'b0, 16'h0000, 8'h00, 9'h000, 4'h1, 1'b1, 1'b1}, // R10 no strobe
    '{8'd5,  1'b1, 16'h3000, 8'h01, 9'h100, 4'h1, 1'b1, 1'b1}, // R5 set bit 8
    '{8'd6,  1'b1, 16'h2000, 8'h00, 9'h100, 4'h1, 1'b1, 1'b1}  // R6 low byte zero
  };

  task automatic check(input int req, input logic [8:0] rom, input logic [3:0] ram,
                       input logic en, input logic rum);
    n_vec++;
    if (rom_bank !== rom || ram_bank !== ram || ram_en !== en || rumble !== rum) begin
      n_bad++;
      $display("FAIL R%0d: got rom=%h ram=%h en=%b rum=%b, expected rom=%h ram=%h en=%b rum=%b",
               req, rom_bank, ram_bank, ram_en, rumble, rom, ram, en, rum);
    end
  endtask

  task automatic write(input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = wr; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 9'h001, 4'h0, 1'b0, 1'b0); // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 9'h001, 4'h0, 1'b0, 1'b0); // R1 after release

    for (int i = 0; i < NV; i++) begin
      write(VEC[i].wr, VEC[i].addr, VEC[i].data);
      check(int'(VEC[i].req), VEC[i].rom, VEC[i].ram, VEC[i].en, VEC[i].rum);
    end

    // R7 and R11: plain build keeps all four bits, never drives the motor
    write(1'b1, 16'h4000, 8'h0F);
    n_vec++;
    if (p_ram !== 4'hF || p_rum !== 1'b0) begin
      n_bad++;
      $display("FAIL R7/R11: got ram=%h rum=%b, expected ram=f rum=0", p_ram, p_rum);
    end
    check(8, 9'h100, 4'h7, 1'b1, 1'b1); // R8 rumble build on same write

    // R8: motor bit clear turns rumble off, bank keeps low bits
    write(1'b1, 16'h5123, 8'h02);
    check(8, 9'h100, 4'h2, 1'b1, 1'b0);

    // R1: reset in the middle of a run restores every output
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 9'h001, 4'h0, 1'b0, 1'b0);
    n_vec++;
    if (p_rom !== 9'h001 || p_ram !== 4'h0 || p_en !== 1'b0 || p_rum !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: plain got rom=%h ram=%h en=%b rum=%b, expected 001 0 0 0",
               p_rom, p_ram, p_en, p_rum);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R6: zero straight after reset
    write(1'b1, 16'h2000, 8'h00);
    check(6, 9'h000, 4'h0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule